// File: doc/BRIEF.md
# CAN Acceptance Filter Router

This block sits behind a CAN message assembly stage. Each completed frame is presented for one cycle: a 29-bit identifier, a flag for extended frames, and the first two data bytes. The block compares the frame against six programmable filters grouped under two masks. It then decides whether the frame is loaded into receive buffer 0, loaded into receive buffer 1, or dropped. One cycle later it issues a load strobe that names the target buffer, together with the number of the filter that accepted the frame.

Each buffer has a full flag. The flag blocks further loads until software clears it, and an accepted frame that finds its buffer full raises that buffer's overflow flag instead. An optional rollover path redirects frames accepted for a full buffer 0 into buffer 1. A listen-only input steers every frame into buffer 0. Two active-low pins can report the full flags, act as plain outputs, or be switched off. The filter and mask registers are writable only while a configuration input is high.

Top module: `can_accept_router`

## Requirements
- R1: Per identifier bit, a mask bit of 0 accepts regardless of the filter, and a mask bit of 1 accepts only if the frame bit equals the filter bit. Filters 0 and 1 use mask 0; filters 2 to 5 use mask 1.
- R2: Buffer 0's filters (0, 1) take precedence over buffer 1's filters (2 to 5). Among matching filters the lowest number wins, and a frame loads at most one buffer.
- R3: For an extended frame (flag 1) the compared word is the 29-bit identifier. For a standard frame it is {2'b00, id[10:0], data0, data1}, and mask bits 28:27 are ignored. A filter matches only frames whose extended flag equals the filter's extended bit, which is write-data bit 29.
- R4: The per-buffer receive mode works as follows. 00 uses the filters. 01 lets a filter match standard frames only. 10 lets a filter match extended frames only. 11 accepts every frame for that buffer, reporting hit 0 for buffer 0 and hit 2 for buffer 1.
- R5: A load sets the buffer's full flag. While the flag is set, a frame accepted for that buffer does not load and sets the buffer's overflow flag. Writing 1 to a bit of the full-clear or overflow-clear input clears that flag on the next edge.
- R6: With rollover enabled and buffer 0 full, a frame accepted by filter 0 or 1 is loaded into buffer 1 with hit code 000 or 001. If buffer 1 is also full, overflow flag 1 is set.
- R7: Buffer 0 reports a 1-bit hit (0 = filter 0, 1 = filter 1). Buffer 1 reports a 3-bit hit, where values 2 to 5 name filters 2 to 5.
- R8: Each buffer pin uses a 2-bit config (buffer n uses bits 2n+1:2n). 01 drives the pin low while the full flag is set. 10 drives the pin with the software value bit. 00 and 11 disable the pin: output enable 0, pin value 1.
- R9: While listen-only is high, every frame is accepted for buffer 0 with hit 0, whatever the masks and filters hold.
- R10: Register select values 0 to 5 address filters 0 to 5, and 6 and 7 address masks 0 and 1. Writes take effect only while config mode is high. Read data is zero while config mode is low.
- R11: The load strobe, target buffer and hit code appear in the cycle after the frame-valid pulse. The strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 1 | Config mode; enables register writes and reads |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 3 | Register select (0-5 filters, 6-7 masks) |
| reg_wdata_i | input | 30 | Write data; bit 29 is the filter extended bit |
| reg_rdata_o | output | 30 | Read data for the selected register |
| rxm0_i | input | 2 | Receive mode, buffer 0 |
| rxm1_i | input | 2 | Receive mode, buffer 1 |
| rollover_en_i | input | 1 | Enables rollover from buffer 0 to buffer 1 |
| listen_only_i | input | 1 | Accepts every frame into buffer 0 |
| msg_valid_i | input | 1 | One-cycle pulse for a completed frame |
| msg_id_i | input | 29 | Frame identifier |
| msg_ext_i | input | 1 | Extended frame flag |
| msg_d0_i | input | 8 | Data byte 0 |
| msg_d1_i | input | 8 | Data byte 1 |
| full_clr_i | input | 2 | Per-buffer full-flag clear |
| ovf_clr_i | input | 2 | Per-buffer overflow-flag clear |
| load_o | output | 1 | Load strobe |
| load_buf_o | output | 1 | Target buffer of the load |
| hit0_o | output | 1 | Buffer 0 filter hit |
| hit1_o | output | 3 | Buffer 1 filter hit |
| full_o | output | 2 | Buffer full (receive interrupt) flags |
| ovf_o | output | 2 | Overflow flags |
| bf_cfg_i | input | 4 | Buffer pin configs, 2 bits per buffer |
| bf_val_i | input | 2 | Software values for plain-output pins |
| bf_n_o | output | 2 | Active-low buffer pins |
| bf_oe_o | output | 2 | Pin output enables (0 = high impedance) |

## Verification
The table-driven part presents standard and extended frames that differ in exactly one field at a time: a data byte bit, an identifier bit under a don't-care mask bit, the extended flag, or identifier bits above bit 10 of a standard frame. Each mismatch must be rejected and each don't-care must be tolerated. Frames that match both a buffer 0 filter and a buffer 1 filter, or two buffer 1 filters, separate the buffer precedence and lowest-number rules from mere matching. The directed sequences fill buffers to expose overflow against rollover, step each receive mode, force listen-only, attempt writes outside config mode, and walk the pin configurations.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  localparam int STD_ID_W = 11;
  localparam int STD_W    = STD_ID_W + 16;

  localparam logic [1:0] RXM_FILT = 2'b00;
  localparam logic [1:0] RXM_STD  = 2'b01;
  localparam logic [1:0] RXM_EXT  = 2'b10;
  localparam logic [1:0] RXM_ALL  = 2'b11;

  localparam logic [1:0] PIN_IRQ  = 2'b01;
  localparam logic [1:0] PIN_GPO  = 2'b10;
endpackage

// File: rtl/can_af_regs.sv
module can_af_regs
  import can_af_pkg::*;
#(
  parameter int ID_W  = 29,
  parameter int NF    = 6,
  parameter int NM    = 2,
  localparam int SEL_W = $clog2(NF + NM),
  localparam int DW    = ID_W + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_mode_i,
  input  logic                       we_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  output logic [NF-1:0][DW-1:0]      filt_o,
  output logic [NM-1:0][ID_W-1:0]    mask_o
);
  logic wr_en;
  assign wr_en = cfg_mode_i & we_i;

  for (genvar i = 0; i < NF; i++) begin : g_filt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                filt_o[i] <= '0;
      else if (wr_en && sel_i == SEL_W'(i))       filt_o[i] <= wdata_i;
    end
  end

  for (genvar j = 0; j < NM; j++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mask_o[j] <= '0;
      else if (wr_en && sel_i == SEL_W'(NF + j))  mask_o[j] <= wdata_i[ID_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (cfg_mode_i) begin
      for (int k = 0; k < NF; k++)
        if (sel_i == SEL_W'(k)) rdata_o = filt_o[k];
      for (int k = 0; k < NM; k++)
        if (sel_i == SEL_W'(NF + k)) rdata_o = {1'b0, mask_o[k]};
    end
  end
endmodule

// File: rtl/can_af_match.sv
module can_af_match
  import can_af_pkg::*;
#(
  parameter int ID_W = 29,
  parameter int NF   = 6,
  parameter int B0F  = 2,
  localparam int HW  = $clog2(NF),
  localparam int DW  = ID_W + 1
) (
  input  logic                    msg_ext_i,
  input  logic [ID_W-1:0]         msg_id_i,
  input  logic [7:0]              msg_d0_i,
  input  logic [7:0]              msg_d1_i,
  input  logic [NF-1:0][DW-1:0]   filt_i,
  input  logic [1:0][ID_W-1:0]    mask_i,
  input  logic [1:0]              rxm0_i,
  input  logic [1:0]              rxm1_i,
  input  logic                    listen_i,
  output logic                    acc0_o,
  output logic                    acc1_o,
  output logic                    hit0_o,
  output logic [HW-1:0]           hit1_o
);
  logic [ID_W-1:0]      key;
  logic [1:0][ID_W-1:0] eff_mask;
  logic [NF-1:0]        hitv;
  logic                 all0, all1;

  assign key = msg_ext_i ? msg_id_i
             : {{(ID_W-STD_W){1'b0}}, msg_id_i[STD_ID_W-1:0], msg_d0_i, msg_d1_i};

  for (genvar m = 0; m < 2; m++) begin : g_emask
    assign eff_mask[m] = msg_ext_i ? mask_i[m]
                       : {{(ID_W-STD_W){1'b0}}, mask_i[m][STD_W-1:0]};
  end

  for (genvar i = 0; i < NF; i++) begin : g_flt
    localparam int M = (i < B0F) ? 0 : 1;
    logic [1:0] mode;
    logic       type_ok;
    assign mode    = (i < B0F) ? rxm0_i : rxm1_i;
    assign type_ok = (mode == RXM_STD) ? !msg_ext_i
                   : (mode == RXM_EXT) ? msg_ext_i : 1'b1;
    assign hitv[i] = (((key ^ filt_i[i][ID_W-1:0]) & eff_mask[M]) == '0)
                   && (filt_i[i][ID_W] == msg_ext_i) && type_ok;
  end

  assign all0   = listen_i | (rxm0_i == RXM_ALL);
  assign all1   = (rxm1_i == RXM_ALL);
  assign acc0_o = all0 | (|hitv[B0F-1:0]);
  assign hit0_o = all0 ? 1'b0 : ~hitv[0];
  assign acc1_o = all1 | (|hitv[NF-1:B0F]);

  always_comb begin
    hit1_o = HW'(B0F);
    if (!all1)
      for (int k = NF - 1; k >= B0F; k--)
        if (hitv[k]) hit1_o = HW'(k);
  end
endmodule

// File: rtl/can_af_route.sv
module can_af_route #(
  parameter int HW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          acc0_i,
  input  logic          acc1_i,
  input  logic          hit0_i,
  input  logic [HW-1:0] hit1_i,
  input  logic          rollover_en_i,
  input  logic [1:0]    full_clr_i,
  input  logic [1:0]    ovf_clr_i,
  output logic          load_o,
  output logic          load_buf_o,
  output logic          hit0_o,
  output logic [HW-1:0] hit1_o,
  output logic [1:0]    full_o,
  output logic [1:0]    ovf_o
);
  logic          ld_d, buf_d, h0_d;
  logic [HW-1:0] h1_d;
  logic [1:0]    set_full, set_ovf;

  always_comb begin
    ld_d     = 1'b0;
    buf_d    = 1'b0;
    h0_d     = hit0_o;
    h1_d     = hit1_o;
    set_full = '0;
    set_ovf  = '0;
    if (valid_i) begin
      if (acc0_i) begin
        if (!full_o[0]) begin
          ld_d = 1'b1; set_full[0] = 1'b1; h0_d = hit0_i;
        end else if (rollover_en_i) begin
          if (!full_o[1]) begin
            ld_d = 1'b1; buf_d = 1'b1; set_full[1] = 1'b1; h1_d = HW'(hit0_i);
          end else set_ovf[1] = 1'b1;
        end else set_ovf[0] = 1'b1;
      end else if (acc1_i) begin
        if (!full_o[1]) begin
          ld_d = 1'b1; buf_d = 1'b1; set_full[1] = 1'b1; h1_d = hit1_i;
        end else set_ovf[1] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o     <= 1'b0;
      load_buf_o <= 1'b0;
      hit0_o     <= 1'b0;
      hit1_o     <= '0;
      full_o     <= '0;
      ovf_o      <= '0;
    end else begin
      load_o     <= ld_d;
      load_buf_o <= buf_d;
      hit0_o     <= h0_d;
      hit1_o     <= h1_d;
      full_o     <= (full_o & ~full_clr_i) | set_full;
      ovf_o      <= (ovf_o & ~ovf_clr_i) | set_ovf;
    end
  end
endmodule

// File: rtl/can_af_pins.sv
module can_af_pins
  import can_af_pkg::*;
#(
  parameter int NB = 2
) (
  input  logic [2*NB-1:0] cfg_i,
  input  logic [NB-1:0]   val_i,
  input  logic [NB-1:0]   full_i,
  output logic [NB-1:0]   pin_n_o,
  output logic [NB-1:0]   oe_o
);
  for (genvar i = 0; i < NB; i++) begin : g_pin
    logic [1:0] c;
    assign c          = cfg_i[2*i +: 2];
    assign pin_n_o[i] = (c == PIN_IRQ) ? ~full_i[i]
                      : (c == PIN_GPO) ? val_i[i] : 1'b1;
    assign oe_o[i]    = (c == PIN_IRQ) || (c == PIN_GPO);
  end
endmodule

// File: rtl/can_accept_router.sv
module can_accept_router #(
  parameter int ID_W = 29,
  parameter int NF   = 6,
  parameter int B0F  = 2,
  localparam int DW    = ID_W + 1,
  localparam int SEL_W = $clog2(NF + 2),
  localparam int HW    = $clog2(NF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_mode_i,
  input  logic             reg_we_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic [1:0]       rxm0_i,
  input  logic [1:0]       rxm1_i,
  input  logic             rollover_en_i,
  input  logic             listen_only_i,
  input  logic             msg_valid_i,
  input  logic [ID_W-1:0]  msg_id_i,
  input  logic             msg_ext_i,
  input  logic [7:0]       msg_d0_i,
  input  logic [7:0]       msg_d1_i,
  input  logic [1:0]       full_clr_i,
  input  logic [1:0]       ovf_clr_i,
  output logic             load_o,
  output logic             load_buf_o,
  output logic             hit0_o,
  output logic [HW-1:0]    hit1_o,
  output logic [1:0]       full_o,
  output logic [1:0]       ovf_o,
  input  logic [3:0]       bf_cfg_i,
  input  logic [1:0]       bf_val_i,
  output logic [1:0]       bf_n_o,
  output logic [1:0]       bf_oe_o
);
  logic [NF-1:0][DW-1:0]   filt;
  logic [1:0][ID_W-1:0]    mask;
  logic                    acc0, acc1, m_hit0;
  logic [HW-1:0]           m_hit1;

  can_af_regs #(.ID_W(ID_W), .NF(NF), .NM(2)) u_regs (
    .clk_i, .rst_ni, .cfg_mode_i,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .filt_o(filt), .mask_o(mask)
  );

  can_af_match #(.ID_W(ID_W), .NF(NF), .B0F(B0F)) u_match (
    .msg_ext_i, .msg_id_i, .msg_d0_i, .msg_d1_i,
    .filt_i(filt), .mask_i(mask), .rxm0_i, .rxm1_i,
    .listen_i(listen_only_i),
    .acc0_o(acc0), .acc1_o(acc1), .hit0_o(m_hit0), .hit1_o(m_hit1)
  );

  can_af_route #(.HW(HW)) u_route (
    .clk_i, .rst_ni, .valid_i(msg_valid_i),
    .acc0_i(acc0), .acc1_i(acc1), .hit0_i(m_hit0), .hit1_i(m_hit1),
    .rollover_en_i, .full_clr_i, .ovf_clr_i,
    .load_o, .load_buf_o, .hit0_o, .hit1_o, .full_o, .ovf_o
  );

  can_af_pins #(.NB(2)) u_pins (
    .cfg_i(bf_cfg_i), .val_i(bf_val_i), .full_i(full_o),
    .pin_n_o(bf_n_o), .oe_o(bf_oe_o)
  );
endmodule

// File: rtl/can_af_checker.sv
module can_af_checker #(
  parameter int ID_W = 29,
  parameter int NF   = 6,
  parameter int B0F  = 2,
  localparam int DW  = ID_W + 1,
  localparam int HW  = $clog2(NF)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_mode_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          msg_valid_i,
  input logic          rollover_en_i,
  input logic          load_o,
  input logic          load_buf_o,
  input logic [HW-1:0] hit1_o,
  input logic [1:0]    full_o,
  input logic [1:0]    ovf_o
);
  assert_load_after_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(msg_valid_i));

  assert_load0_sets_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !load_buf_o) |-> full_o[0]);

  assert_no_load_into_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && load_buf_o) |-> !$past(full_o[1]));

  assert_hit1_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && load_buf_o) |-> (hit1_o < HW'(NF)));

  assert_rollover_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && load_buf_o && hit1_o < HW'(B0F)) |-> $past(rollover_en_i));

  assert_ovf_needs_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o[0]) |-> $past(msg_valid_i));

  assert_read_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_i |-> (reg_rdata_o == '0));
endmodule

bind can_accept_router can_af_checker #(.ID_W(ID_W), .NF(NF), .B0F(B0F)) u_chk (.*);

// File: tb/can_accept_router_test.sv
`timescale 1ns/100ps
module can_accept_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_mode, reg_we, rollover_en, listen_only, msg_valid, msg_ext;
  logic [2:0]  reg_sel;
  logic [29:0] reg_wdata, reg_rdata;
  logic [1:0]  rxm0, rxm1, full_clr, ovf_clr, full, ovf, bf_val, bf_n, bf_oe;
  logic [28:0] msg_id;
  logic [7:0]  msg_d0, msg_d1;
  logic        load, load_buf, hit0;
  logic [2:0]  hit1;
  logic [3:0]  bf_cfg;

  can_accept_router uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg_mode), .reg_we_i(reg_we),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rxm0_i(rxm0), .rxm1_i(rxm1), .rollover_en_i(rollover_en),
    .listen_only_i(listen_only), .msg_valid_i(msg_valid), .msg_id_i(msg_id),
    .msg_ext_i(msg_ext), .msg_d0_i(msg_d0), .msg_d1_i(msg_d1),
    .full_clr_i(full_clr), .ovf_clr_i(ovf_clr), .load_o(load),
    .load_buf_o(load_buf), .hit0_o(hit0), .hit1_o(hit1), .full_o(full),
    .ovf_o(ovf), .bf_cfg_i(bf_cfg), .bf_val_i(bf_val), .bf_n_o(bf_n),
    .bf_oe_o(bf_oe)
  );

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic        ext;
    logic [28:0] id;
    logic [7:0]  d0;
    logic [7:0]  d1;
    logic        ld;
    logic        bsel;
    logic [2:0]  hit;
  } vec_t;

  // filters: 0 std 123/AA/55, 1 ext 1ABCDEF0, 2 std 7FF/00/xx,
  // 3 ext 000012xx, 4 ext 1ABCDExx, 5 ext 000012xx; mask0 exact, mask1 low byte free
  localparam vec_t VECS [9] = '{
    '{1'b0, 29'h00000123, 8'hAA, 8'h55, 1'b1, 1'b0, 3'd0},  // R1 R3 exact std
    '{1'b0, 29'h00000123, 8'hAA, 8'h54, 1'b0, 1'b0, 3'd0},  // R3 data byte bit
    '{1'b1, 29'h1ABCDEF0, 8'h00, 8'h00, 1'b1, 1'b0, 3'd1},  // R2 buf0 beats filt4
    '{1'b1, 29'h1ABCDEF1, 8'h00, 8'h00, 1'b1, 1'b1, 3'd4},  // R1 masked low bit
    '{1'b1, 29'h00001234, 8'h00, 8'h00, 1'b1, 1'b1, 3'd3},  // R2 lowest of 3,5
    '{1'b0, 29'h000007FF, 8'h00, 8'h99, 1'b1, 1'b1, 3'd2},  // R3 d1 don't care
    '{1'b0, 29'h000007FF, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0},  // R1 d0 bit mismatch
    '{1'b1, 29'h0123AA55, 8'h00, 8'h00, 1'b0, 1'b0, 3'd0},  // R3 ext flag mismatch
    '{1'b0, 29'h1FFFF923, 8'hAA, 8'h55, 1'b1, 1'b0, 3'd0}   // R3 high id bits ignored
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [29:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(input logic ext, input logic [28:0] id,
                      input logic [7:0] d0, input logic [7:0] d1);
    @(negedge clk);
    msg_valid = 1'b1; msg_ext = ext; msg_id = id; msg_d0 = d0; msg_d1 = d1;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic exp_load(input logic ld, input logic b, input logic [2:0] h,
                          input string req);
    logic [2:0] act_h;
    act_h = b ? hit1 : {2'b00, hit0};
    if (ld) chk(load && load_buf == b && act_h == h, req,
                {27'd0, load, load_buf, act_h}, {27'd0, ld, b, h});
    else    chk(!load, req, {31'd0, load}, 32'd0);
  endtask

  task automatic clr_all();
    @(negedge clk);
    full_clr = 2'b11; ovf_clr = 2'b11;
    @(negedge clk);
    full_clr = 2'b00; ovf_clr = 2'b00;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  end

  initial begin
    cfg_mode = 1'b1; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    rxm0 = 2'b00; rxm1 = 2'b00; rollover_en = 1'b0; listen_only = 1'b0;
    msg_valid = 1'b0; msg_ext = 1'b0; msg_id = '0; msg_d0 = '0; msg_d1 = '0;
    full_clr = '0; ovf_clr = '0; bf_cfg = '0; bf_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk(!load && full == 2'b00 && ovf == 2'b00, "R5 reset",
        {27'd0, load, full, ovf}, 32'd0);
    chk(reg_rdata == '0, "R10 reset read", {2'd0, reg_rdata}, 32'd0);
    chk(bf_oe == 2'b00 && bf_n == 2'b11, "R8 reset pins",
        {28'd0, bf_oe, bf_n}, 32'h3);

    wr(3'd0, {1'b0, 29'h0123AA55});
    wr(3'd1, {1'b1, 29'h1ABCDEF0});
    wr(3'd2, {1'b0, 29'h07FF0000});
    wr(3'd3, {1'b1, 29'h00001200});
    wr(3'd4, {1'b1, 29'h1ABCDE00});
    wr(3'd5, {1'b1, 29'h00001200});
    wr(3'd6, {1'b0, 29'h1FFFFFFF});
    wr(3'd7, {1'b0, 29'h1FFFFF00});
    @(negedge clk);
    reg_sel = 3'd4; #1;
    chk(reg_rdata == {1'b1, 29'h1ABCDE00}, "R10 readback",
        {2'd0, reg_rdata}, {2'd0, 1'b1, 29'h1ABCDE00});
    cfg_mode = 1'b0;

    for (int i = 0; i < 9; i++) begin
      send(VECS[i].ext, VECS[i].id, VECS[i].d0, VECS[i].d1);
      exp_load(VECS[i].ld, VECS[i].bsel, VECS[i].hit, $sformatf("R2 vector %0d", i));
      clr_all();
    end

    // R11 single-cycle strobe
    send(1'b0, 29'h123, 8'hAA, 8'h55);
    exp_load(1'b1, 1'b0, 3'd0, "R11 strobe");
    @(negedge clk);
    chk(!load, "R11 strobe one cycle", {31'd0, load}, 32'd0);
    // R5 blocked by full, overflow
    send(1'b0, 29'h123, 8'hAA, 8'h55);
    exp_load(1'b0, 1'b0, 3'd0, "R5 full blocks");
    chk(full == 2'b01 && ovf == 2'b01, "R5 overflow", {28'd0, full, ovf}, 32'h5);
    clr_all();
    chk(full == 2'b00 && ovf == 2'b00, "R5 clear", {28'd0, full, ovf}, 32'd0);

    // R6 rollover
    rollover_en = 1'b1;
    send(1'b0, 29'h123, 8'hAA, 8'h55);
    send(1'b1, 29'h1ABCDEF0, 8'h00, 8'h00);
    exp_load(1'b1, 1'b1, 3'd1, "R6 rollover hit 001");
    send(1'b0, 29'h123, 8'hAA, 8'h55);
    exp_load(1'b0, 1'b0, 3'd0, "R6 both full");
    chk(ovf == 2'b10 && full == 2'b11, "R6 overflow on buf1",
        {28'd0, full, ovf}, 32'hE);
    clr_all();
    send(1'b1, 29'h1ABCDEF0, 8'h00, 8'h00);
    send(1'b0, 29'h123, 8'hAA, 8'h55);
    exp_load(1'b1, 1'b1, 3'd0, "R6 rollover hit 000");
    clr_all();
    rollover_en = 1'b0;

    // R4 receive modes
    rxm1 = 2'b01;
    send(1'b1, 29'h1234, 8'h00, 8'h00);
    exp_load(1'b0, 1'b0, 3'd0, "R4 std-only rejects ext");
    send(1'b0, 29'h7FF, 8'h00, 8'h00);
    exp_load(1'b1, 1'b1, 3'd2, "R4 std-only accepts std");
    clr_all();
    rxm1 = 2'b10;
    send(1'b0, 29'h7FF, 8'h00, 8'h00);
    exp_load(1'b0, 1'b0, 3'd0, "R4 ext-only rejects std");
    send(1'b1, 29'h1234, 8'h00, 8'h00);
    exp_load(1'b1, 1'b1, 3'd3, "R4 ext-only accepts ext");
    clr_all();
    rxm1 = 2'b11;
    send(1'b0, 29'h555, 8'h12, 8'h34);
    exp_load(1'b1, 1'b1, 3'd2, "R4 accept-all buf1");
    clr_all();
    rxm1 = 2'b00;
    rxm0 = 2'b11;
    send(1'b1, 29'h0ABCDEF, 8'h00, 8'h00);
    exp_load(1'b1, 1'b0, 3'd0, "R4 accept-all buf0");
    clr_all();
    rxm0 = 2'b01;
    send(1'b1, 29'h1ABCDEF0, 8'h00, 8'h00);
    exp_load(1'b1, 1'b1, 3'd4, "R4 buf0 std-only passes ext to buf1");
    clr_all();
    rxm0 = 2'b00;

    // R9 listen-only
    listen_only = 1'b1;
    send(1'b1, 29'h0ABCDEF, 8'h00, 8'h00);
    exp_load(1'b1, 1'b0, 3'd0, "R9 listen-only");
    clr_all();
    listen_only = 1'b0;

    // R10 write gating
    @(negedge clk);
    reg_sel = 3'd0; #1;
    chk(reg_rdata == '0, "R10 read outside cfg", {2'd0, reg_rdata}, 32'd0);
    wr(3'd0, {1'b1, 29'h00000000});
    send(1'b0, 29'h123, 8'hAA, 8'h55);
    exp_load(1'b1, 1'b0, 3'd0, "R10 write ignored");
    cfg_mode = 1'b1;
    @(negedge clk);
    reg_sel = 3'd0; #1;
    chk(reg_rdata == {1'b0, 29'h0123AA55}, "R10 filter unchanged",
        {2'd0, reg_rdata}, {3'd0, 29'h0123AA55});
    cfg_mode = 1'b0;
    clr_all();

    // R8 pins
    bf_cfg = 4'b10_01; bf_val = 2'b10;
    #1;
    chk(bf_oe == 2'b11 && bf_n == 2'b11, "R8 irq idle / gpo high",
        {28'd0, bf_oe, bf_n}, 32'hF);
    send(1'b0, 29'h123, 8'hAA, 8'h55);
    chk(bf_n == 2'b10, "R8 irq low when full", {30'd0, bf_n}, 32'h2);
    bf_val = 2'b00; #1;
    chk(bf_n == 2'b00, "R8 gpo follows value", {30'd0, bf_n}, 32'h0);
    bf_cfg = 4'b11_00; #1;
    chk(bf_oe == 2'b00 && bf_n == 2'b11, "R8 disabled", {28'd0, bf_oe, bf_n}, 32'h3);
    clr_all();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule